// File: doc/BRIEF.md
# Transactional Read/Write-Set Conflict Tracker

This block keeps the read set and the write set of one local transaction, at cache-line granularity, and compares every access made by other agents against them. Each local access that arrives while the transaction runs is recorded in a small fully associative table. A line gets its own entry the first time it is touched, and the entry carries one flag for "read" and one for "written". Snooped accesses from elsewhere in the system are checked against that table under asymmetric rules. A remote write to any tracked line is a conflict. A remote read is a conflict only when the line has been written locally.

The snoop port has no input that says whether the remote agent is itself transactional, so plain accesses conflict in the same way as transactional ones. Two sticky flags are the only outputs. One reports a conflict. The other reports that a new line could not be recorded because the table was full. The transaction controller reads the flags and pulses `clear` when it commits or aborts, which empties the table. The block holds no data, performs no rollback and does not sequence commits.

Top module: `txn_line_tracker`

## Requirements
- R1: Addresses are compared by line only. Bits [LINE_OFFS-1:0] (bits [5:0] by default, a 64-byte line) are ignored. Two addresses in the same line match even when their bytes do not overlap, so false sharing counts as a conflict.
- R2: A local access (`loc_valid`=1) records its line. `loc_write`=0 marks the line read and `loc_write`=1 marks it written. A line that is both read and written occupies a single entry, and a repeated access to a recorded line never takes a new entry.
- R3: A snoop write (`snp_valid`=1, `snp_write`=1) to a line in the read set raises `conflict`. No input marks the remote agent as transactional.
- R4: A snoop read or a snoop write to a line in the write set raises `conflict`.
- R5: A snoop read to a line that is only read-marked does not raise `conflict`. A snoop to an untracked line, including the neighbouring line, does not raise `conflict`.
- R6: A snoop is checked against the sets as they stood at the start of its cycle. A local access in the same cycle to the same line does not make that snoop conflict, but later snoops see the new record.
- R7: `conflict` and `overflow` are registered. Each appears one cycle after the access that causes it and stays at 1 until `clear` or reset.
- R8: When all ENTRIES (16) entries are valid, a local access to a new line raises `overflow`. An access to a line already recorded does not raise it.
- R9: `clear` empties every entry and drops both flags in one cycle. It takes priority over a local access or a snoop in the same cycle, and that access is neither recorded nor checked.
- R10: Asynchronous active-low reset empties the table and sets both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty the sets and drop the flags (commit or abort) |
| loc_valid | input | 1 | Local transactional access present |
| loc_write | input | 1 | Local access is a write (1) or a read (0) |
| loc_addr | input | ADDR_W | Local access byte address |
| snp_valid | input | 1 | Remote access present |
| snp_write | input | 1 | Remote access is a write (1) or a read (0) |
| snp_addr | input | ADDR_W | Remote access byte address |
| conflict | output | 1 | Sticky conflict flag |
| overflow | output | 1 | Sticky capacity-overflow flag |

## Verification
The hardest condition to reach from the ports is a full table: the capacity rule only applies once every entry holds a distinct line. The bench therefore issues sixteen local reads to consecutive lines. It then shows that touching one of those lines again keeps `overflow` low, and that a seventeenth line raises it. The same-cycle ordering in R6 also needs a deliberate setup, because a local access and a snoop to the same line must land on one clock edge. The bench drives that pair together, confirms that no conflict results, and then repeats the snoop alone.

// File: rtl/txl_pkg.sv
package txl_pkg;

  // Per-line permission marks held in one table entry
  typedef struct packed {
    logic rd;
    logic wr;
  } txl_marks_t;

  // Remote access against the marks of a matching line
  function automatic logic remote_clashes(input txl_marks_t m, input logic remote_write);
    return m.wr | (remote_write & m.rd);
  endfunction

endpackage

// File: rtl/txl_match.sv
module txl_match #(
  parameter int N     = 16,
  parameter int TAG_W = 26
) (
  input  logic [N-1:0]            ent_valid,
  input  logic [N-1:0][TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            hit
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = ent_valid[i] && (ent_tag[i] == key);
  end

endmodule

// File: rtl/txl_free_pick.sv
module txl_free_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] ent_valid,
  output logic [N-1:0] grant,
  output logic         any_free
);

  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!ent_valid[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any_free = ~&ent_valid;

endmodule

// File: rtl/txl_set_table.sv
module txl_set_table #(
  parameter int N     = 16,
  parameter int TAG_W = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    rec_en,
  input  logic                    rec_write,
  input  logic [TAG_W-1:0]        rec_tag,
  input  logic [N-1:0]            rec_hit,
  input  logic [N-1:0]            rec_alloc,
  output logic [N-1:0]            ent_valid,
  output logic [N-1:0][TAG_W-1:0] ent_tag,
  output txl_pkg::txl_marks_t [N-1:0] ent_marks
);
  import txl_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic       v_d;
    txl_marks_t m_d;
    logic       tag_en;

    always_comb begin
      v_d    = ent_valid[i];
      m_d    = ent_marks[i];
      tag_en = 1'b0;
      if (clear) begin
        v_d = 1'b0;
        m_d = '0;
      end else if (rec_en && rec_hit[i]) begin
        m_d.rd = ent_marks[i].rd | ~rec_write;
        m_d.wr = ent_marks[i].wr |  rec_write;
      end else if (rec_en && rec_alloc[i]) begin
        v_d    = 1'b1;
        m_d.rd = ~rec_write;
        m_d.wr = rec_write;
        tag_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[i] <= 1'b0;
        ent_marks[i] <= '0;
      end else begin
        ent_valid[i] <= v_d;
        ent_marks[i] <= m_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_tag[i] <= '0;
      end else if (tag_en) begin
        ent_tag[i] <= rec_tag;
      end
    end
  end

endmodule

// File: rtl/txn_line_tracker.sv
module txn_line_tracker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_OFFS = 6,
  parameter int ENTRIES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              loc_valid,
  input  logic              loc_write,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              conflict,
  output logic              overflow
);
  import txl_pkg::*;

  localparam int TAG_W = ADDR_W - LINE_OFFS;

  logic [TAG_W-1:0]              loc_tag, snp_tag;
  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  txl_marks_t [ENTRIES-1:0]      ent_marks;
  logic [ENTRIES-1:0]            loc_hit, snp_hit, alloc_gnt, alloc_sel;
  logic [ENTRIES-1:0]            clash_vec;
  logic                          any_free, loc_any_hit, rec_en;
  logic                          snp_hit_r_any, snp_hit_w_any;
  logic                          conflict_evt, overflow_evt;
  logic                          conflict_d, overflow_d;
  logic                          conflict_q, overflow_q;

  // Line tags: byte offset within a line is dropped
  assign loc_tag = loc_addr[ADDR_W-1:LINE_OFFS];
  assign snp_tag = snp_addr[ADDR_W-1:LINE_OFFS];

  txl_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_loc_match (
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .key       (loc_tag),
    .hit       (loc_hit)
  );

  txl_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_snp_match (
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .key       (snp_tag),
    .hit       (snp_hit)
  );

  txl_free_pick #(.N(ENTRIES)) u_pick (
    .ent_valid (ent_valid),
    .grant     (alloc_gnt),
    .any_free  (any_free)
  );

  assign loc_any_hit = |loc_hit;
  assign alloc_sel   = loc_any_hit ? '0 : alloc_gnt;
  assign rec_en      = loc_valid & ~clear;

  txl_set_table #(.N(ENTRIES), .TAG_W(TAG_W)) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .rec_en    (rec_en),
    .rec_write (loc_write),
    .rec_tag   (loc_tag),
    .rec_hit   (loc_hit),
    .rec_alloc (alloc_sel),
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .ent_marks (ent_marks)
  );

  // Snoop evaluation against the sets at the start of the cycle
  for (genvar i = 0; i < ENTRIES; i++) begin : g_clash
    assign clash_vec[i] = snp_hit[i] & remote_clashes(ent_marks[i], snp_write);
  end

  always_comb begin
    snp_hit_r_any = 1'b0;
    snp_hit_w_any = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      snp_hit_r_any = snp_hit_r_any | (snp_hit[i] & ent_marks[i].rd);
      snp_hit_w_any = snp_hit_w_any | (snp_hit[i] & ent_marks[i].wr);
    end
  end

  assign conflict_evt = snp_valid & ~clear & (|clash_vec);
  assign overflow_evt = rec_en & ~loc_any_hit & ~any_free;

  // Sticky flag next state
  always_comb begin
    conflict_d = conflict_q;
    overflow_d = overflow_q;
    if (clear) begin
      conflict_d = 1'b0;
      overflow_d = 1'b0;
    end else begin
      if (conflict_evt) conflict_d = 1'b1;
      if (overflow_evt) overflow_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conflict_q <= 1'b0;
      overflow_q <= 1'b0;
    end else begin
      conflict_q <= conflict_d;
      overflow_q <= overflow_d;
    end
  end

  assign conflict = conflict_q;
  assign overflow = overflow_q;

endmodule

// File: rtl/txl_tracker_chk.sv
module txl_tracker_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic         snp_valid,
  input logic         snp_write,
  input logic         conflict,
  input logic         overflow,
  input logic [N-1:0] ent_valid,
  input logic [N-1:0] loc_hit,
  input logic [N-1:0] alloc_gnt,
  input logic         snp_hit_r,
  input logic         snp_hit_w
);

  // R2: a line is held by at most one entry
  a_r2_unique_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(loc_hit));

  // R2: allocation picks a single slot
  a_r2_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_gnt));

  // R4: remote access to a written line flags a conflict
  a_r4_write_set_hit: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !clear && snp_hit_w |=> conflict);

  // R3: remote write to a read line flags a conflict
  a_r3_read_set_write: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_write && !clear && snp_hit_r |=> conflict);

  // R5: no conflict appears without a clashing snoop
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict && !(snp_valid && (snp_hit_w || (snp_write && snp_hit_r))) |=> !conflict);

  // R7: conflict stays until clear
  a_r7_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    conflict && !clear |=> conflict);

  // R7: overflow stays until clear
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear |=> overflow);

  // R8: overflow rises only from a full table
  a_r8_full_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(&ent_valid));

  // R9: clear drops both flags and empties the table
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !conflict && !overflow && (ent_valid == '0));

endmodule

bind txn_line_tracker txl_tracker_chk #(.N(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .snp_valid (snp_valid),
  .snp_write (snp_write),
  .conflict  (conflict),
  .overflow  (overflow),
  .ent_valid (ent_valid),
  .loc_hit   (loc_hit),
  .alloc_gnt (alloc_gnt),
  .snp_hit_r (snp_hit_r_any),
  .snp_hit_w (snp_hit_w_any)
);

// File: tb/sim_txn_line_tracker.sv
module sim_txn_line_tracker;

  localparam int ADDR_W = 32;
  localparam logic [1:0] K_IDLE = 2'd0, K_LOC = 2'd1, K_SNP = 2'd2, K_CLR = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic        wr;
    logic [31:0] addr;
    logic        exp_c;
    logic        exp_o;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{K_CLR, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    '{K_LOC, 1'b0, 32'h0000_1000, 1'b0, 1'b0}, // R2 read mark
    '{K_SNP, 1'b0, 32'h0000_1008, 1'b0, 1'b0}, // R5 read of read line
    '{K_SNP, 1'b1, 32'h0000_1030, 1'b1, 1'b0}, // R3 R1 false sharing
    '{K_CLR, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    '{K_LOC, 1'b1, 32'h0000_2000, 1'b0, 1'b0},
    '{K_SNP, 1'b0, 32'h0000_2004, 1'b1, 1'b0}, // R4 read of written line
    '{K_CLR, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    '{K_LOC, 1'b0, 32'h0000_3000, 1'b0, 1'b0},
    '{K_LOC, 1'b1, 32'h0000_3010, 1'b0, 1'b0}, // R2 both marks one line
    '{K_SNP, 1'b0, 32'h0000_3020, 1'b1, 1'b0}, // R4
    '{K_CLR, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    '{K_LOC, 1'b1, 32'h0000_4000, 1'b0, 1'b0},
    '{K_SNP, 1'b1, 32'h0000_4040, 1'b0, 1'b0}, // R5 next line
    '{K_SNP, 1'b0, 32'h0000_3FC0, 1'b0, 1'b0}  // R5 previous line
  };

  logic              clk, rst_n, clear;
  logic              loc_valid, loc_write, snp_valid, snp_write;
  logic [ADDR_W-1:0] loc_addr, snp_addr;
  logic              conflict, overflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic done = 1'b0;

  txn_line_tracker u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .loc_valid (loc_valid),
    .loc_write (loc_write),
    .loc_addr  (loc_addr),
    .snp_valid (snp_valid),
    .snp_write (snp_write),
    .snp_addr  (snp_addr),
    .conflict  (conflict),
    .overflow  (overflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic clr, input logic lv, input logic lw, input logic [31:0] la,
                       input logic sv, input logic sw, input logic [31:0] sa);
    @(negedge clk);
    clear = clr; loc_valid = lv; loc_write = lw; loc_addr = la;
    snp_valid = sv; snp_write = sw; snp_addr = sa;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; clear = 1'b0;
    loc_valid = 1'b0; loc_write = 1'b0; loc_addr = '0;
    snp_valid = 1'b0; snp_write = 1'b0; snp_addr = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset conflict", conflict, 1'b0);
    chk("R10 reset overflow", overflow, 1'b0);
    rst_n = 1'b1;
    idle();

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].kind == K_CLR,
            VECS[v].kind == K_LOC, VECS[v].wr, VECS[v].addr,
            VECS[v].kind == K_SNP, VECS[v].wr, VECS[v].addr);
      chk($sformatf("R1-vector%0d conflict (R3 R4 R5)", v), conflict, VECS[v].exp_c);
      chk($sformatf("R8 vector%0d overflow", v), overflow, VECS[v].exp_o);
    end

    // R7: registered, one cycle later, sticky
    drive(1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    drive(1'b0, 1'b1, 1'b1, 32'h0000_7000, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    clear = 1'b0; loc_valid = 1'b0; snp_valid = 1'b1; snp_write = 1'b0; snp_addr = 32'h0000_7000;
    chk("R7 not before edge", conflict, 1'b0);
    @(posedge clk); #1;
    chk("R7 after edge", conflict, 1'b1);
    idle(); idle();
    chk("R7 sticky", conflict, 1'b1);

    // R6: same-cycle local write and snoop read to one line
    drive(1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    drive(1'b0, 1'b1, 1'b1, 32'h0000_5000, 1'b1, 1'b0, 32'h0000_5008);
    chk("R6 same cycle no conflict", conflict, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_5008);
    chk("R6 later snoop conflicts", conflict, 1'b1);

    // R9: clear wins over a same-cycle local access and snoop
    drive(1'b1, 1'b1, 1'b1, 32'h0000_6000, 1'b1, 1'b1, 32'h0000_5000);
    chk("R9 clear drops conflict", conflict, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0000_6000);
    chk("R9 access with clear not recorded", conflict, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 32'h0000_5000);
    chk("R9 old lines emptied", conflict, 1'b0);

    // R8: fill the table with 16 distinct lines
    drive(1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    for (int i = 0; i < 16; i++) begin
      drive(1'b0, 1'b1, 1'b0, 32'h0001_0000 + i * 64, 1'b0, 1'b0, 32'h0);
    end
    chk("R8 sixteen lines fit", overflow, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 32'h0001_0004, 1'b0, 1'b0, 32'h0);
    chk("R8 recorded line no overflow", overflow, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0001_03C0);
    chk("R5 last read line read snoop", conflict, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 32'h0001_03C0);
    chk("R3 last entry write snoop", conflict, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 32'h0002_0000, 1'b0, 1'b0, 32'h0);
    chk("R8 seventeenth line overflow", overflow, 1'b1);
    idle();
    chk("R7 overflow sticky", overflow, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R9 clear drops overflow", overflow, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 32'h0002_0000, 1'b0, 1'b0, 32'h0);
    chk("R9 room after clear", overflow, 1'b0);

    // R10: asynchronous reset in mid-run empties the table
    drive(1'b0, 1'b1, 1'b1, 32'h0003_0000, 1'b1, 1'b1, 32'h0002_0000);
    chk("R3 before reset", conflict, 1'b1);
    idle();
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async conflict", conflict, 1'b0);
    chk("R10 async overflow", overflow, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0003_0000);
    chk("R10 table empty after reset", conflict, 1'b0);
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule